// File: doc/BRIEF.md
# Four-Stage Forwarding Pipeline Core

This block is a small in-order integer core split into four stages: instruction fetch, decode with register read, execute and register write-back. Three pipeline registers sit between the stages. The first holds the fetched word. The second holds the decoded operation, both source operand values and the destination. The third holds the ALU result and its destination. Instructions come from an internal program store that is filled through a write port while the core is held in reset. The register file has eight entries of `XLEN` bits, and register 0 reads as zero.

Read-after-write dependencies are found in decode. A static mode input `fwd_en` selects how they are resolved. With it low, decode holds the dependent instruction until the producer has written the register file, and a bubble goes into execute for each held cycle. With it high, two paths avoid the hold. Decode takes a value still in the write stage straight from the result register. A multiplexer at each ALU input takes the previous instruction's result instead of the captured operand. Jumps are resolved in decode. The instruction fetched behind a jump is discarded and becomes a bubble. A retire trace reports each instruction that reaches write-back.

Top module: `pipe4_core`

## Requirements
- R1: While `rst_n` is low, `retire_valid`, `stall_o` and `flush_o` are all 0.
- R2: Encoding is opcode [15:12], rd [11:9], rs1 [8:6], rs2 [5:3]. The opcodes are 0 no-op, 1 add, 2 subtract rs1-rs2, 3 and, 4 or, 5 xor, 6 add-immediate with [5:0] sign-extended in place of rs2, and 8 jump to its own PC plus the sign-extended [8:0]. Any other opcode acts as a no-op. The retire trace (PC, destination, value) equals sequential execution of the program, in program order.
- R3: A run of independent instructions retires on consecutive cycles with `stall_o` never high.
- R4: With `fwd_en` low, an instruction that sources the destination of the instruction directly ahead of it is held in decode for exactly two cycles. If the producer is two instructions ahead, the hold is one cycle. `stall_o` is high on each held cycle and never high for three consecutive cycles.
- R5: With `fwd_en` high, `stall_o` stays low and dependent instructions retire back to back with correct values.
- R6: A jump in decode raises `flush_o` for one cycle and discards exactly one wrong-path instruction. The jump target retires two cycles after the jump, and the execute slot that follows the jump does no work.
- R7: Writes to register 0 have no effect, and reading register 0 never causes a hold.
- R8: An instruction that writes no register, or writes register 0, retires with destination 0 and value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 selects bypass paths, 0 selects decode hold; changed only in reset |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | PCW | Program store write address |
| prog_data | input | 16 | Instruction word to store |
| stall_o | output | 1 | Decode held this cycle |
| flush_o | output | 1 | Jump in decode discards the fetched word |
| retire_valid | output | 1 | An instruction is in write-back |
| retire_pc | output | PCW | PC of the retiring instruction |
| retire_rd | output | 3 | Destination written, 0 if none |
| retire_value | output | XLEN | Value written, 0 if none |

## Verification
The hardest case to reach from the ports is a dependent instruction decoded while its producer is in the write stage, after an earlier hold has already shifted the pipeline. This case separates a correct two-cycle hold from a one-cycle hold that reads a stale value. The programs chain dependencies at distance one and distance two, with a no-op used as padding. Each program runs in both modes against an in-bench sequential model. Retire cycle stamps check the exact hold length and the single bubble after each jump.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned RIDX_W  = 3;
  localparam int unsigned NREG    = 1 << RIDX_W;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_AND  = 4'h3,
    OP_OR   = 4'h4,
    OP_XOR  = 4'h5,
    OP_ADDI = 4'h6,
    OP_JMP  = 4'h8
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu;
    logic    use_a;
    logic    use_b;
    logic    wr;
    logic    imm;
    logic    jmp;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [3:0] opc);
    ctrl_t c;
    c = '{alu: ALU_ADD, default: 1'b0};
    case (opc)
      OP_ADD:  begin c.use_a = 1'b1; c.use_b = 1'b1; c.wr = 1'b1; end
      OP_SUB:  begin c.use_a = 1'b1; c.use_b = 1'b1; c.wr = 1'b1; c.alu = ALU_SUB; end
      OP_AND:  begin c.use_a = 1'b1; c.use_b = 1'b1; c.wr = 1'b1; c.alu = ALU_AND; end
      OP_OR:   begin c.use_a = 1'b1; c.use_b = 1'b1; c.wr = 1'b1; c.alu = ALU_OR; end
      OP_XOR:  begin c.use_a = 1'b1; c.use_b = 1'b1; c.wr = 1'b1; c.alu = ALU_XOR; end
      OP_ADDI: begin c.use_a = 1'b1; c.imm = 1'b1; c.wr = 1'b1; end
      OP_JMP:  c.jmp = 1'b1;
      default: c.wr = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pipe4_regfile.sv
module pipe4_regfile
  import pipe4_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0][RIDX_W-1:0] raddr,
  output logic [1:0][XLEN-1:0]   rdata,
  input  logic                   we,
  input  logic [RIDX_W-1:0]      waddr,
  input  logic [XLEN-1:0]        wdata
);
  logic [XLEN-1:0] regs_q [NREG];

  // Written at the edge that ends the write stage; entry 0 is never written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREG); i++) regs_q[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rport
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs_q[raddr[p]];
  end
endmodule

// File: rtl/pipe4_alu.sv
module pipe4_alu
  import pipe4_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe4_hazard.sv
module pipe4_hazard #(
  parameter int unsigned RW = 3
) (
  input  logic              fwd_en,
  input  logic              d_valid,
  input  logic [1:0]        d_use,
  input  logic [1:0][RW-1:0] d_rs,
  input  logic [1:0]        x_use,
  input  logic [1:0][RW-1:0] x_rs,
  input  logic              x_valid,
  input  logic              x_wr,
  input  logic [RW-1:0]     x_rd,
  input  logic              w_valid,
  input  logic              w_wr,
  input  logic [RW-1:0]     w_rd,
  output logic              stall,
  output logic [1:0]        d_byp,
  output logic [1:0]        x_fwd
);
  logic [1:0] hit_x, hit_w, hit_xw;

  for (genvar p = 0; p < 2; p++) begin : g_opnd
    // decode operand against producer in execute / in write-back
    assign hit_x[p]  = d_use[p] && (d_rs[p] != '0) && x_valid && x_wr && (x_rd == d_rs[p]);
    assign hit_w[p]  = d_use[p] && (d_rs[p] != '0) && w_valid && w_wr && (w_rd == d_rs[p]);
    // execute operand against producer now in write-back
    assign hit_xw[p] = x_use[p] && (x_rs[p] != '0) && w_valid && w_wr && (w_rd == x_rs[p]);
  end

  assign stall = d_valid && !fwd_en && ((|hit_x) || (|hit_w));
  assign d_byp = fwd_en ? hit_w  : 2'b00;
  assign x_fwd = fwd_en ? hit_xw : 2'b00;
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter  int unsigned XLEN       = 16,
  parameter  int unsigned IMEM_DEPTH = 32,
  localparam int unsigned PCW        = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fwd_en,
  input  logic               prog_we,
  input  logic [PCW-1:0]     prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  output logic               stall_o,
  output logic               flush_o,
  output logic               retire_valid,
  output logic [PCW-1:0]     retire_pc,
  output logic [RIDX_W-1:0]  retire_rd,
  output logic [XLEN-1:0]    retire_value
);
  typedef struct packed {
    logic               valid;
    logic [PCW-1:0]     pc;
    logic [INSTR_W-1:0] instr;
  } fbuf_t;

  typedef struct packed {
    logic                   valid;
    logic [PCW-1:0]         pc;
    ctrl_t                  ctrl;
    logic [RIDX_W-1:0]      rd;
    logic [1:0][RIDX_W-1:0] rs;
    logic [1:0][XLEN-1:0]   src;
  } dbuf_t;

  typedef struct packed {
    logic              valid;
    logic [PCW-1:0]    pc;
    logic              wr;
    logic [RIDX_W-1:0] rd;
    logic [XLEN-1:0]   rslt;
  } xbuf_t;

  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [PCW-1:0]     pc_q, pc_d;
  fbuf_t              b1_q, b1_d;
  dbuf_t              b2_q, b2_d;
  xbuf_t              b3_q, b3_d;
  logic               fe_en;

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  // ---------------- decode ----------------
  ctrl_t                  d_ctrl;
  logic [1:0][RIDX_W-1:0] d_rs;
  logic [1:0]             d_use, d_byp;
  logic [1:0][XLEN-1:0]   rf_rd, d_opnd;
  logic [XLEN-1:0]        d_imm;
  logic [PCW-1:0]         jmp_tgt;
  logic                   stall, flush;

  assign d_ctrl  = decode_ctrl(b1_q.instr[15:12]);
  assign d_rs[0] = b1_q.instr[8:6];
  assign d_rs[1] = b1_q.instr[5:3];
  assign d_use   = {d_ctrl.use_b, d_ctrl.use_a};
  assign d_imm   = XLEN'($signed(b1_q.instr[5:0]));
  assign jmp_tgt = b1_q.pc + PCW'($signed(b1_q.instr[8:0]));
  assign flush   = b1_q.valid && d_ctrl.jmp && !stall;

  pipe4_regfile #(.XLEN(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (d_rs),
    .rdata (rf_rd),
    .we    (b3_q.valid && b3_q.wr),
    .waddr (b3_q.rd),
    .wdata (b3_q.rslt)
  );

  for (genvar p = 0; p < 2; p++) begin : g_dsrc
    assign d_opnd[p] = d_byp[p] ? b3_q.rslt : rf_rd[p];
  end

  // ---------------- execute ----------------
  logic [1:0]           x_fwd;
  logic [1:0][XLEN-1:0] x_opnd;
  logic [XLEN-1:0]      x_res;

  for (genvar p = 0; p < 2; p++) begin : g_xsrc
    assign x_opnd[p] = x_fwd[p] ? b3_q.rslt : b2_q.src[p];
  end

  pipe4_alu #(.XLEN(XLEN)) u_alu (
    .op (b2_q.ctrl.alu),
    .a  (x_opnd[0]),
    .b  (x_opnd[1]),
    .y  (x_res)
  );

  pipe4_hazard #(.RW(RIDX_W)) u_hz (
    .fwd_en  (fwd_en),
    .d_valid (b1_q.valid),
    .d_use   (d_use),
    .d_rs    (d_rs),
    .x_use   ({b2_q.ctrl.use_b, b2_q.ctrl.use_a}),
    .x_rs    (b2_q.rs),
    .x_valid (b2_q.valid),
    .x_wr    (b2_q.ctrl.wr),
    .x_rd    (b2_q.rd),
    .w_valid (b3_q.valid),
    .w_wr    (b3_q.wr),
    .w_rd    (b3_q.rd),
    .stall   (stall),
    .d_byp   (d_byp),
    .x_fwd   (x_fwd)
  );

  // ---------------- next state ----------------
  assign fe_en = !stall;

  always_comb begin
    pc_d       = flush ? jmp_tgt : pc_q + PCW'(1);
    b1_d.valid = !flush;
    b1_d.pc    = pc_q;
    b1_d.instr = imem[pc_q];

    b2_d.valid  = b1_q.valid && !stall;
    b2_d.pc     = b1_q.pc;
    b2_d.ctrl   = d_ctrl;
    b2_d.rd     = b1_q.instr[11:9];
    b2_d.rs     = d_rs;
    b2_d.src[0] = d_opnd[0];
    b2_d.src[1] = d_ctrl.imm ? d_imm : d_opnd[1];

    b3_d.valid = b2_q.valid;
    b3_d.pc    = b2_q.pc;
    b3_d.wr    = b2_q.ctrl.wr;
    b3_d.rd    = b2_q.rd;
    b3_d.rslt  = x_res;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      b1_q <= '0;
      b2_q <= '0;
      b3_q <= '0;
    end else begin
      if (fe_en) begin
        pc_q <= pc_d;
        b1_q <= b1_d;
      end
      b2_q <= b2_d;
      b3_q <= b3_d;
    end
  end

  assign stall_o      = stall;
  assign flush_o      = flush;
  assign retire_valid = b3_q.valid;
  assign retire_pc    = b3_q.pc;
  assign retire_rd    = b3_q.wr ? b3_q.rd : '0;
  assign retire_value = (b3_q.wr && (b3_q.rd != '0)) ? b3_q.rslt : '0;
endmodule

// File: rtl/pipe4_core_chk.sv
module pipe4_core_chk
  import pipe4_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fwd_en,
  input logic              stall_o,
  input logic              flush_o,
  input logic              retire_valid,
  input logic [RIDX_W-1:0] retire_rd,
  input logic [XLEN-1:0]   retire_value
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!retire_valid && !stall_o && !flush_o)); // R1

  AST_HOLD_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && $past(stall_o)) |=> !stall_o); // R4

  AST_BYPASS_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en |-> !stall_o); // R5

  AST_JUMP_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> ##2 !retire_valid); // R6

  AST_ZERO_DEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && (retire_rd == '0)) |-> (retire_value == '0)); // R8
endmodule

bind pipe4_core pipe4_core_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fwd_en       (fwd_en),
  .stall_o      (stall_o),
  .flush_o      (flush_o),
  .retire_valid (retire_valid),
  .retire_rd    (retire_rd),
  .retire_value (retire_value)
);

// File: tb/pipe4_core_test.sv
`timescale 1ns/1ps
module pipe4_core_test;
  localparam int XLEN  = 16;
  localparam int DEPTH = 32;
  localparam int PCW   = 5;

  typedef struct packed {
    logic [PCW-1:0]  pc;
    logic [2:0]      rd;
    logic [XLEN-1:0] val;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fwd_en = 1'b0;
  logic             prog_we = 1'b0;
  logic [PCW-1:0]   prog_addr = '0;
  logic [15:0]      prog_data = '0;
  logic             stall_o, flush_o, retire_valid;
  logic [PCW-1:0]   retire_pc;
  logic [2:0]       retire_rd;
  logic [XLEN-1:0]  retire_value;

  pipe4_core #(.XLEN(XLEN), .IMEM_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .stall_o(stall_o), .flush_o(flush_o),
    .retire_valid(retire_valid), .retire_pc(retire_pc),
    .retire_rd(retire_rd), .retire_value(retire_value)
  );

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0, total = 0, stall_cnt = 0, nret = 0;
  bit running = 0;
  bit done = 0;
  exp_t exp_q[$];
  logic [15:0] prog [DEPTH];
  int rcyc [64];
  int rval [64];
  int rpc  [64];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] enc_r(input logic [3:0] op, input int rd, input int a, input int b);
    return {op, 3'(rd), 3'(a), 3'(b), 3'b000};
  endfunction
  function automatic logic [15:0] enc_i(input int rd, input int a, input int imm);
    return {4'h6, 3'(rd), 3'(a), 6'(imm)};
  endfunction
  function automatic logic [15:0] enc_j(input int off);
    return {4'h8, 3'b000, 9'(off)};
  endfunction

  // sequential reference: driver side of the scoreboard
  task automatic build_model(input int steps);
    logic [XLEN-1:0] regs [8];
    int pc;
    for (int r = 0; r < 8; r++) regs[r] = '0;
    pc = 0;
    exp_q.delete();
    for (int s = 0; s < steps; s++) begin
      logic [15:0] ins;
      logic [3:0] op;
      int rd, a, b;
      logic [XLEN-1:0] v;
      bit wr;
      exp_t e;
      ins = prog[pc];
      op = ins[15:12]; rd = ins[11:9]; a = ins[8:6]; b = ins[5:3];
      wr = 1'b1; v = '0;
      case (op)
        4'h1: v = regs[a] + regs[b];
        4'h2: v = regs[a] - regs[b];
        4'h3: v = regs[a] & regs[b];
        4'h4: v = regs[a] | regs[b];
        4'h5: v = regs[a] ^ regs[b];
        4'h6: v = regs[a] + XLEN'($signed(ins[5:0]));
        default: wr = 1'b0;
      endcase
      e.pc  = PCW'(pc);
      e.rd  = wr ? 3'(rd) : 3'd0;
      e.val = (wr && rd != 0) ? v : '0;
      exp_q.push_back(e);
      if (wr && rd != 0) regs[rd] = v;
      if (op == 4'h8) pc = (pc + int'($signed(ins[8:0]))) & (DEPTH - 1);
      else pc = (pc + 1) & (DEPTH - 1);
    end
  endtask

  // monitor: pops and compares as the design retires
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (stall_o) stall_cnt++;
      if (retire_valid && exp_q.size() > 0) begin
        exp_t e;
        string tag;
        e = exp_q.pop_front();
        tag = (e.rd == 0) ? "R8" : (fwd_en ? "R5" : "R2");
        nchk++;
        if (retire_pc !== e.pc || retire_rd !== e.rd || retire_value !== e.val) begin
          nerr++;
          $display("FAIL %s retire: actual pc=%0d rd=%0d val=%h expected pc=%0d rd=%0d val=%h",
                   tag, retire_pc, retire_rd, retire_value, e.pc, e.rd, e.val);
        end
        rcyc[nret] = cyc; rval[nret] = int'(retire_value); rpc[nret] = int'(retire_pc);
        nret++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    total++;
    if (total > 150000 && !done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", total);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic start_test(input bit fwd, input int steps);
    @(posedge clk); #1;
    rst_n = 1'b0; fwd_en = fwd;
    for (int a = 0; a < DEPTH; a++) begin
      @(posedge clk); #1;
      prog_we = 1'b1; prog_addr = PCW'(a); prog_data = prog[a];
    end
    @(posedge clk); #1;
    prog_we = 1'b0;
    build_model(steps);
    @(negedge clk);
    check(retire_valid == 1'b0, "R1", "retire_valid in reset", retire_valid, 0);
    check(stall_o == 1'b0 && flush_o == 1'b0, "R1", "stall/flush in reset",
          {stall_o, flush_o}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1; running = 1;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() > 0 && t < 400) begin
      @(posedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R2", "items left after run", exp_q.size(), 0);
    @(posedge clk); #1;
    running = 0;
  endtask

  task automatic clear_prog();
    for (int a = 0; a < DEPTH; a++) prog[a] = 16'h0000;
  endtask

  task automatic prog_a();
    clear_prog();
    prog[0]  = enc_i(1, 0, 5);
    prog[1]  = enc_i(2, 0, 3);
    prog[2]  = enc_r(4'h1, 3, 1, 2);
    prog[3]  = enc_r(4'h2, 4, 3, 1);
    prog[4]  = enc_r(4'h5, 5, 4, 3);
    prog[5]  = enc_i(0, 0, 9);
    prog[6]  = enc_r(4'h4, 6, 0, 0);
    prog[7]  = enc_j(3);
    prog[8]  = enc_i(7, 0, 1);
    prog[9]  = enc_i(7, 0, 2);
    prog[10] = enc_r(4'h3, 7, 5, 4);
    prog[11] = enc_i(1, 1, -1);
    prog[12] = enc_j(0);
  endtask

  task automatic prog_b();
    clear_prog();
    prog[0] = enc_i(1, 0, 4);
    prog[1] = 16'h0000;
    prog[2] = enc_i(2, 1, 1);
    prog[3] = enc_r(4'h1, 3, 2, 2);
    prog[4] = enc_j(0);
  endtask

  task automatic prog_c();
    clear_prog();
    prog[0] = enc_i(1, 0, 1);
    prog[1] = enc_i(2, 0, -3);
    prog[2] = enc_i(3, 0, 31);
    prog[3] = enc_i(4, 0, -32);
    prog[4] = enc_r(4'h2, 5, 0, 0);
    prog[5] = enc_j(0);
  endtask

  initial begin
    int b, s0;
    // program A without bypass
    prog_a();
    b = nret; s0 = stall_cnt;
    start_test(1'b0, 12);
    drain();
    check(stall_cnt - s0 == 6, "R4", "hold cycles, chained deps", stall_cnt - s0, 6);
    check(rpc[b+8] == 10, "R6", "pc after jump", rpc[b+8], 10);
    check(rcyc[b+8] - rcyc[b+7] == 2, "R6", "jump to target gap", rcyc[b+8] - rcyc[b+7], 2);
    check(rcyc[b+11] - rcyc[b+10] == 2, "R6", "self jump gap", rcyc[b+11] - rcyc[b+10], 2);
    check(rval[b+6] == 0, "R7", "r0 write ignored", rval[b+6], 0);

    // program A with bypass
    prog_a();
    b = nret; s0 = stall_cnt;
    start_test(1'b1, 12);
    drain();
    check(stall_cnt - s0 == 0, "R5", "hold cycles with bypass", stall_cnt - s0, 0);
    check(rcyc[b+4] - rcyc[b] == 4, "R5", "dependent chain back to back", rcyc[b+4] - rcyc[b], 4);
    check(rcyc[b+8] - rcyc[b+7] == 2, "R6", "jump gap with bypass", rcyc[b+8] - rcyc[b+7], 2);

    // program B without bypass: distance two then distance one
    prog_b();
    b = nret; s0 = stall_cnt;
    start_test(1'b0, 6);
    drain();
    check(stall_cnt - s0 == 3, "R4", "hold cycles, dist 2 + dist 1", stall_cnt - s0, 3);
    check(rcyc[b+2] - rcyc[b+1] == 2, "R4", "distance-two hold", rcyc[b+2] - rcyc[b+1], 2);
    check(rcyc[b+3] - rcyc[b+2] == 3, "R4", "distance-one hold", rcyc[b+3] - rcyc[b+2], 3);

    // program B with bypass
    prog_b();
    b = nret; s0 = stall_cnt;
    start_test(1'b1, 6);
    drain();
    check(stall_cnt - s0 == 0, "R5", "hold cycles with bypass", stall_cnt - s0, 0);
    check(rcyc[b+3] - rcyc[b] == 3, "R5", "no bubbles with bypass", rcyc[b+3] - rcyc[b], 3);

    // program C: independent stream
    prog_c();
    b = nret; s0 = stall_cnt;
    start_test(1'b0, 7);
    drain();
    check(stall_cnt - s0 == 0, "R3", "hold cycles, independent", stall_cnt - s0, 0);
    for (int k = 0; k < 5; k++)
      check(rcyc[b+k+1] - rcyc[b+k] == 1, "R3", "consecutive retire", rcyc[b+k+1] - rcyc[b+k], 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule